// File: doc/BRIEF.md
# Accumulator Row Group Address Sequencer

This block walks the accumulator rows touched by one multi-vector multiply-subtract step. A single start pulse captures a 32-bit base select value, a one-bit offset field, the group count (two or four source registers) and the vector length. The vector length is given as the base-2 log of the accumulator row count. The block then emits one address per cycle: the accumulator row, the register offset within the source group, the sub-lane phase, and the two source register numbers that go with that row.

The row array is split into equal partitions, one per source register. The starting row is the sum of base and offset, reduced modulo the partition size and rounded down to a multiple of four. Each register visits four consecutive rows from its group base, and the group base then jumps by one whole partition. The datapath that multiplies, subtracts and stores results follows this sequence. The block holds no arithmetic and no storage of its own.

Top module: `acc_row_seq`

## Requirements
- R1: After reset, step_valid and done are low, and they stay low until a start pulse is accepted.
- R2: A start pulse while idle captures all inputs. step_valid rises in the next cycle and stays high for exactly 4*nreg consecutive cycles, where nreg is 4 when grp4=1 and 2 when grp4=0.
- R3: The row count is 2^L, where L is rows_log2 clamped to the range 4 to MAX_ROWS_LOG2 (default 8). The partition stride is the row count divided by nreg.
- R4: The first row is s - (s mod 4), where s = ((base_sel + 4*offs_bit) mod 2^32) mod stride.
- R5: Within one register, phase runs 0,1,2,3 on successive steps, and row_idx equals the group base plus phase.
- R6: After phase 3, reg_off goes up by one, phase returns to 0 and the group base grows by the stride, so row_idx = first + reg_off*stride + phase.
- R7: src_n is formed as {zn_fld,1'b0}+reg_off when grp4=0 and as {zn_fld[2:0],2'b00}+reg_off when grp4=1. src_m is formed from zm_fld in the same way. Both are 5 bits wide.
- R8: done is high on the final step only, together with step_valid. step_valid is low in the cycle that follows.
- R9: A start pulse while a sequence is running, including one on its final step, is ignored. The running sequence keeps its captured values, and no new sequence begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse |
| base_sel | input | 32 | Base select value |
| offs_bit | input | 1 | Offset field (offset = 4*offs_bit) |
| grp4 | input | 1 | 1: four-register group, 0: two-register group |
| rows_log2 | input | LOG_W (4) | log2 of accumulator row count |
| zn_fld | input | 4 | First source register field |
| zm_fld | input | 4 | Second source register field |
| step_valid | output | 1 | A step is presented this cycle |
| row_idx | output | ROW_W (8) | Accumulator row index |
| reg_off | output | 2 | Register offset r within the group |
| phase | output | 2 | Sub-lane phase i |
| src_n | output | 5 | First source register number |
| src_m | output | 5 | Second source register number |
| done | output | 1 | Final step of the sequence |

## Verification
The hardest case to reach from the ports is a start pulse that arrives while a sequence runs, most of all on the final step, where busy is about to drop. The bench raises start on a chosen mid-sequence step and on the done step, and at the same time flips every other input. It then checks that the rest of the sequence still follows the values captured at launch and that step_valid falls right after done. Base values near 2^32 and rows_log2 values outside the legal range drive the wrap and clamp paths.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  function automatic logic [7:0] clamp_log2(input logic [7:0] v,
                                            input logic [7:0] lo,
                                            input logic [7:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // source register base: multiple of the group size
  function automatic logic [4:0] src_base(input logic [3:0] fld,
                                          input logic       four);
    return four ? {fld[2:0], 2'b00} : {fld, 1'b0};
  endfunction

  // number of partition-shift bits for the group count
  function automatic logic [7:0] grp_shift(input logic four);
    return four ? 8'd2 : 8'd1;
  endfunction

endpackage

// File: rtl/acc_seq_geom.sv
module acc_seq_geom
  import acc_seq_pkg::*;
#(
  parameter int MAX_LOG2 = 8,
  parameter int MIN_LOG2 = 4,
  parameter int LOG_W    = 4,
  parameter int ROW_W    = MAX_LOG2
) (
  input  logic [31:0]      base_sel,
  input  logic             offs_bit,
  input  logic             grp4,
  input  logic [LOG_W-1:0] rows_log2,
  output logic [ROW_W-1:0] stride,
  output logic [ROW_W-1:0] first_row
);
  logic [7:0]       eff_log2;
  logic [7:0]       str_log2;
  logic [31:0]      sum;
  logic [31:0]      mask32;
  logic [31:0]      mod32;
  logic [ROW_W-1:0] low_bits;

  always_comb begin
    eff_log2 = clamp_log2(8'(rows_log2), 8'(MIN_LOG2), 8'(MAX_LOG2));
    str_log2 = eff_log2 - grp_shift(grp4);
    stride   = ROW_W'(1) << str_log2;
    sum      = base_sel + {29'd0, offs_bit, 2'b00};
    mask32   = (32'd1 << str_log2) - 32'd1;
    mod32    = sum & mask32;
    low_bits = mod32[ROW_W-1:0];
    first_row = {low_bits[ROW_W-1:2], 2'b00};
  end
endmodule

// File: rtl/acc_seq_ctr.sv
module acc_seq_ctr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       grp4_in,
  output logic       launch,
  output logic       busy,
  output logic [1:0] phase,
  output logic [1:0] reg_off,
  output logic       grp4_q,
  output logic       last_step
);
  logic [1:0] last_reg;

  assign launch    = start & ~busy;
  assign last_reg  = grp4_q ? 2'd3 : 2'd1;
  assign last_step = busy && (phase == 2'd3) && (reg_off == last_reg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      phase   <= 2'd0;
      reg_off <= 2'd0;
      grp4_q  <= 1'b0;
    end else if (launch) begin
      busy    <= 1'b1;
      phase   <= 2'd0;
      reg_off <= 2'd0;
      grp4_q  <= grp4_in;
    end else if (busy) begin
      phase <= phase + 2'd1;
      if (phase == 2'd3) reg_off <= reg_off + 2'd1;
      if (last_step) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/acc_seq_idx.sv
module acc_seq_idx #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             busy,
  input  logic [1:0]       phase,
  input  logic [ROW_W-1:0] first_row,
  input  logic [ROW_W-1:0] stride,
  output logic             grp_step,
  output logic [ROW_W-1:0] row_idx
);
  logic [ROW_W-1:0] grp_base;
  logic [ROW_W-1:0] stride_q;

  assign grp_step = busy && (phase == 2'd3);
  assign row_idx  = grp_base + ROW_W'(phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_base <= '0;
      stride_q <= '0;
    end else if (launch) begin
      grp_base <= first_row;
      stride_q <= stride;
    end else if (grp_step) begin
      grp_base <= grp_base + stride_q;
    end
  end
endmodule

// File: rtl/acc_row_seq.sv
module acc_row_seq
  import acc_seq_pkg::*;
#(
  parameter int MAX_ROWS_LOG2 = 8,
  parameter int MIN_ROWS_LOG2 = 4,
  localparam int LOG_W = $clog2(MAX_ROWS_LOG2 + 1),
  localparam int ROW_W = MAX_ROWS_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      base_sel,
  input  logic             offs_bit,
  input  logic             grp4,
  input  logic [LOG_W-1:0] rows_log2,
  input  logic [3:0]       zn_fld,
  input  logic [3:0]       zm_fld,
  output logic             step_valid,
  output logic [ROW_W-1:0] row_idx,
  output logic [1:0]       reg_off,
  output logic [1:0]       phase,
  output logic [4:0]       src_n,
  output logic [4:0]       src_m,
  output logic             done
);
  logic             launch;
  logic             busy;
  logic             grp4_q;
  logic             last_step;
  logic             grp_step;
  logic [ROW_W-1:0] stride;
  logic [ROW_W-1:0] first_row;
  logic [3:0]       zn_q;
  logic [3:0]       zm_q;

  acc_seq_geom #(
    .MAX_LOG2(MAX_ROWS_LOG2), .MIN_LOG2(MIN_ROWS_LOG2),
    .LOG_W(LOG_W), .ROW_W(ROW_W)
  ) u_geom (
    .base_sel(base_sel), .offs_bit(offs_bit), .grp4(grp4),
    .rows_log2(rows_log2), .stride(stride), .first_row(first_row)
  );

  acc_seq_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .start(start), .grp4_in(grp4),
    .launch(launch), .busy(busy), .phase(phase), .reg_off(reg_off),
    .grp4_q(grp4_q), .last_step(last_step)
  );

  acc_seq_idx #(.ROW_W(ROW_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy),
    .phase(phase), .first_row(first_row), .stride(stride),
    .grp_step(grp_step), .row_idx(row_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zn_q <= 4'd0;
      zm_q <= 4'd0;
    end else if (launch) begin
      zn_q <= zn_fld;
      zm_q <= zm_fld;
    end
  end

  assign step_valid = busy;
  assign done       = last_step;
  assign src_n      = src_base(zn_q, grp4_q) + 5'(reg_off);
  assign src_m      = src_base(zm_q, grp4_q) + 5'(reg_off);
endmodule

// File: rtl/acc_row_seq_chk.sv
module acc_row_seq_chk #(
  parameter int ROW_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             step_valid,
  input logic             done,
  input logic             grp_step,
  input logic [1:0]       phase,
  input logic [1:0]       reg_off,
  input logic [ROW_W-1:0] row_idx
);
  assert_first_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !step_valid |=> step_valid && phase == 2'd0 && reg_off == 2'd0);

  assert_start_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && phase == 2'd0 && reg_off == 2'd0 |-> row_idx[1:0] == 2'b00);

  assert_phase_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && phase != 2'd3 |=> step_valid && phase == $past(phase) + 2'd1
                                    && row_idx == $past(row_idx) + ROW_W'(1));

  assert_reg_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grp_step && !done |=> phase == 2'd0 && reg_off == $past(reg_off) + 2'd1);

  assert_done_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> step_valid && phase == 2'd3);

  assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !step_valid);
endmodule

bind acc_row_seq acc_row_seq_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .step_valid(step_valid),
  .done(done), .grp_step(grp_step), .phase(phase), .reg_off(reg_off),
  .row_idx(row_idx)
);

// File: tb/acc_row_seq_bench.sv
module acc_row_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_sel = '0;
  logic        offs_bit = 1'b0;
  logic        grp4 = 1'b0;
  logic [3:0]  rows_log2 = 4'd8;
  logic [3:0]  zn_fld = '0;
  logic [3:0]  zm_fld = '0;
  logic        step_valid;
  logic [7:0]  row_idx;
  logic [1:0]  reg_off;
  logic [1:0]  phase;
  logic [4:0]  src_n;
  logic [4:0]  src_m;
  logic        done;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  acc_row_seq u_acc_row_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base_sel(base_sel),
    .offs_bit(offs_bit), .grp4(grp4), .rows_log2(rows_log2),
    .zn_fld(zn_fld), .zm_fld(zm_fld), .step_valid(step_valid),
    .row_idx(row_idx), .reg_off(reg_off), .phase(phase),
    .src_n(src_n), .src_m(src_m), .done(done)
  );

  // stimulus table: base, offset bit, group-of-four, rows log2
  localparam logic [31:0] T_BASE [10] = '{32'd0, 32'd5, 32'd13, 32'd127,
    32'd200, 32'hFFFF_FFFC, 32'hFFFF_FFFF, 32'd63, 32'd31, 32'h8000_0007};
  localparam logic T_OFFS [10] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1,
    1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic T_G4 [10] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0,
    1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [3:0] T_LG [10] = '{4'd8, 4'd4, 4'd5, 4'd8, 4'd6,
    4'd7, 4'd8, 4'd4, 4'd2, 4'd15};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_row(input logic [31:0] b, input bit o, input bit g4,
                                 input int lg, input int r, input int i);
    int l, rows, strd;
    logic [31:0] s;
    int v;
    l = (lg < 4) ? 4 : ((lg > 8) ? 8 : lg);      // R3
    rows = 1 << l;
    strd = rows / (g4 ? 4 : 2);
    s = b + (o ? 32'd4 : 32'd0);                 // R4
    v = int'(s % strd);
    v = v - (v % 4);
    return v + r * strd + i;                     // R5 R6
  endfunction

  function automatic int ref_src(input logic [3:0] f, input bit g4, input int r);
    return g4 ? (int'(f) % 8) * 4 + r : int'(f) * 2 + r;   // R7
  endfunction

  // poke: step index at which a foreign start is raised (-1 none)
  task automatic run_seq(input logic [31:0] b, input bit o, input bit g4,
                         input logic [3:0] lg, input logic [3:0] zn,
                         input logic [3:0] zm, input int poke);
    int nreg;
    nreg = g4 ? 4 : 2;
    base_sel = b; offs_bit = o; grp4 = g4; rows_log2 = lg;
    zn_fld = zn; zm_fld = zm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4 * nreg; k++) begin
      int r, i, er;
      r = k / 4; i = k % 4;
      er = ref_row(b, o, g4, int'(lg), r, i) % 256;
      check(step_valid === 1'b1, "R2", "step_valid", int'(step_valid), 1);
      check(row_idx == 8'(er), "R6", "row_idx", int'(row_idx), er);
      check(phase == 2'(i) && reg_off == 2'(r), "R5", "phase/reg",
            int'({reg_off, phase}), r * 4 + i);
      check(src_n == 5'(ref_src(zn, g4, r)) && src_m == 5'(ref_src(zm, g4, r)),
            "R7", "src_n/src_m", int'({src_n, src_m}),
            ref_src(zn, g4, r) * 32 + ref_src(zm, g4, r));
      check(done === (k == 4 * nreg - 1), "R8", "done", int'(done),
            int'(k == 4 * nreg - 1));
      if (k == poke) begin                       // R9 foreign start
        start = 1'b1; base_sel = ~b; offs_bit = ~o; grp4 = ~g4;
        rows_log2 = 4'd5; zn_fld = ~zn; zm_fld = ~zm;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check(step_valid === 1'b0 && done === 1'b0, "R8", "idle after done",
          int'(step_valid), 0);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(step_valid === 1'b0 && done === 1'b0, "R1", "reset outputs",
          int'(step_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(step_valid === 1'b0, "R1", "idle before start", int'(step_valid), 0);

    for (int t = 0; t < 10; t++)
      run_seq(T_BASE[t], T_OFFS[t], T_G4[t], T_LG[t], 4'(t + 3), 4'(15 - t), -1);

    for (int t = 0; t < 24; t++)
      run_seq($urandom, 1'($urandom), 1'(t % 2), (t % 4 < 2) ? 4'd5 : 4'd8,
              4'($urandom), 4'($urandom), -1);

    // R3 clamp below and above the legal range
    run_seq(32'd9, 1'b0, 1'b1, 4'd0, 4'd1, 4'd2, -1);
    run_seq(32'd250, 1'b1, 1'b0, 4'd12, 4'd9, 4'd4, -1);
    // R4 wrap of base plus offset across 2^32
    run_seq(32'hFFFF_FFFE, 1'b1, 1'b0, 4'd8, 4'd0, 4'd15, -1);
    // R9 start mid-sequence and on the final step
    run_seq(32'd77, 1'b1, 1'b1, 4'd8, 4'd6, 4'd11, 5);
    run_seq(32'd41, 1'b0, 1'b0, 4'd6, 4'd3, 4'd7, 7);
    run_seq(32'd150, 1'b1, 1'b1, 4'd7, 4'd10, 4'd12, 15);

    // back-to-back: new launch right after an idle cycle
    run_seq(32'd3, 1'b0, 1'b0, 4'd4, 4'd15, 4'd0, -1);
    @(negedge clk);
    check(step_valid === 1'b0, "R9", "no extra run", int'(step_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule